// File: doc/BRIEF.md
# Pipeline Execute Stage with Cause Passthrough

This block is the execute step of a five-step in-order integer pipeline. Each cycle it accepts one bundle from decode: the operation code, both register source values, an already-extended immediate, a select that picks the immediate as the second operand, the register-write enable, the destination/selector field, a shift amount, the instruction address, a fault cause code and a branch-shadow flag. It picks the second operand and evaluates the operation. Arithmetic overflow and conditional trap outcomes become a cause code. Conditional moves may cancel their own write. A hardware-register read returns one of a few machine values. The result travels on to the memory step in a single output register.

An instruction that arrives already marked with a fault never reaches the arithmetic unit. Its cause is kept as it is and its result is zero, so an older fault always wins over anything execute could add. Stall holds the output register. Flush replaces its contents with an empty bubble. The cycle counter and the thread-pointer value come in as inputs, and the smallest cache line size is a parameter.

Top module: `ex_stage`

## Requirements
- R1: While `rst_n` is low, and after it has been released until the first accepted bundle, every output reads zero. This includes `out_valid`, `out_wr_en`, `out_result` and `out_cause` (cause 0 means no fault).
- R2: When `in_use_imm` is 1 the second operand is `in_imm`; when it is 0 the second operand is `in_rt_val`.
- R3: Operation 1 (signed add) and operation 3 (signed subtract) set cause 12 on two's-complement overflow. The result is still the wrapped sum or difference. Operations 0 and 2 (unsigned add and subtract) never set a cause.
- R4: The trap operations set cause 13 when their condition on (rs, operand two) holds, and set cause 0 otherwise. Their result is always 0. The operations are 16 (signed >=), 17 (unsigned >=), 18 (signed <), 19 (unsigned <), 20 (equal) and 21 (not equal).
- R5: When `in_cause` is nonzero, the stored result is 0 and the stored cause equals `in_cause`, whatever the operation and operands are.
- R6: Operation 14 (move-if-zero) returns rs and clears the write enable when operand two is nonzero. Operation 15 (move-if-nonzero) returns rs and clears the write enable when operand two is zero. In every other case the write enable passes through unchanged.
- R7: Operation 22 (hardware-register read) returns a value chosen by the 5-bit `in_rd_sel`. Selector 0 gives 0. Selector 1 gives parameter `MIN_LINE_BYTES`. Selector 2 gives `cycle_count`. Selector 3 gives 1. Selector 29 gives `user_local`. Any other selector gives 0.
- R8: `in_pc`, `in_in_slot` and `in_valid` appear unchanged on `out_pc`, `out_in_slot` and `out_valid` one clock after they are accepted.
- R9: While `stall` is 1 and `flush` is 0, every output holds its value.
- R10: When `flush` is 1, the next clock loads a bubble in which every output is zero. Flush wins over stall.
- R11: Logic and compare operations return the expected value: 4 AND, 5 OR, 6 XOR, 7 NOR, 8 signed set-less-than, 9 unsigned set-less-than (each yields 1 or 0) and 23 pass operand two. Shifts of `in_rt_val` by `in_shamt` are 10 (logical left), 11 (logical right) and 12 (arithmetic right). Operation 13 places operand two's low half in the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the output register |
| flush | input | 1 | Load a bubble into the output register |
| in_valid | input | 1 | Incoming bundle holds an instruction |
| in_op | input | 5 | Operation code |
| in_rs_val | input | DATA_W | First source value |
| in_rt_val | input | DATA_W | Second source value |
| in_imm | input | DATA_W | Extended immediate |
| in_use_imm | input | 1 | Use the immediate as operand two |
| in_wr_en | input | 1 | Register-write enable from decode |
| in_rd_sel | input | 5 | Destination field, hardware-register selector |
| in_shamt | input | 5 | Shift amount |
| in_pc | input | DATA_W | Instruction address |
| in_cause | input | 4 | Incoming fault cause, 0 = none |
| in_in_slot | input | 1 | Instruction sits in a branch shadow |
| cycle_count | input | DATA_W | Live cycle counter value |
| user_local | input | DATA_W | Thread-pointer register value |
| out_valid | output | 1 | Registered valid |
| out_result | output | DATA_W | Registered result |
| out_wr_en | output | 1 | Registered write enable |
| out_pc | output | DATA_W | Registered instruction address |
| out_cause | output | 4 | Registered cause |
| out_in_slot | output | 1 | Registered branch-shadow flag |

## Verification
The embedded properties check the register-level rules on every cycle. Stall holds the outputs and flush yields an empty bundle. An incoming fault comes out with the same cause and a zero result. Address and shadow flag pass through, trap results are zero, and a conditional move whose condition fails drops its write. The exact arithmetic cannot be shown by the properties and comes only from the bench scenarios. Those scenarios cover overflow at the sign boundary, signed against unsigned trap comparisons, every hardware-register selector including an unlisted one, the shift and logic results, and a flush raised during a stall.

// File: rtl/ex_pkg.sv
package ex_pkg;

  localparam int OP_W    = 5;
  localparam int CAUSE_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADDU  = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUBU  = 5'd2,
    OP_SUB   = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLT   = 5'd8,
    OP_SLTU  = 5'd9,
    OP_SLL   = 5'd10,
    OP_SRL   = 5'd11,
    OP_SRA   = 5'd12,
    OP_LUI   = 5'd13,
    OP_MOVZ  = 5'd14,
    OP_MOVN  = 5'd15,
    OP_TGE   = 5'd16,
    OP_TGEU  = 5'd17,
    OP_TLT   = 5'd18,
    OP_TLTU  = 5'd19,
    OP_TEQ   = 5'd20,
    OP_TNE   = 5'd21,
    OP_HWRD  = 5'd22,
    OP_PASSB = 5'd23
  } ex_op_e;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF  = 4'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'd13;

  function automatic logic is_trap_op(input ex_op_e op);
    return (op == OP_TGE) || (op == OP_TGEU) || (op == OP_TLT) ||
           (op == OP_TLTU) || (op == OP_TEQ) || (op == OP_TNE);
  endfunction

endpackage

// File: rtl/ex_operand_sel.sv
module ex_operand_sel #(
  parameter int DATA_W = 32
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [DATA_W-1:0] imm_val,
  output logic [DATA_W-1:0] opnd_b
);

  always_comb begin
    if (use_imm) opnd_b = imm_val;
    else         opnd_b = rt_val;
  end

endmodule

// File: rtl/ex_alu.sv
module ex_alu
  import ex_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  ex_op_e               op,
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  input  logic [DATA_W-1:0]    rt_val,
  input  logic [SH_W-1:0]      shamt,
  output logic [DATA_W-1:0]    result,
  output logic [CAUSE_W-1:0]   cause,
  output logic                 discard
);

  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] sum, diff;
  logic              add_ovf, sub_ovf;
  logic              lt_s, lt_u, eq;

  always_comb begin
    sum     = a + b;
    diff    = a - b;
    add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
    lt_s    = $signed(a) < $signed(b);
    lt_u    = a < b;
    eq      = (a == b);
  end

  always_comb begin
    result  = '0;
    cause   = CAUSE_NONE;
    discard = 1'b0;
    unique case (op)
      OP_ADDU: result = sum;
      OP_ADD: begin
        result = sum;
        if (add_ovf) cause = CAUSE_OVF;
      end
      OP_SUBU: result = diff;
      OP_SUB: begin
        result = diff;
        if (sub_ovf) cause = CAUSE_OVF;
      end
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_NOR:  result = ~(a | b);
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL:  result = rt_val << shamt;
      OP_SRL:  result = rt_val >> shamt;
      OP_SRA:  result = DATA_W'($signed(rt_val) >>> shamt);
      OP_LUI:  result = {b[HALF-1:0], {(DATA_W-HALF){1'b0}}};
      OP_MOVZ: begin
        result  = a;
        discard = (b != '0);
      end
      OP_MOVN: begin
        result  = a;
        discard = (b == '0);
      end
      OP_TGE:  if (!lt_s) cause = CAUSE_TRAP;
      OP_TGEU: if (!lt_u) cause = CAUSE_TRAP;
      OP_TLT:  if (lt_s)  cause = CAUSE_TRAP;
      OP_TLTU: if (lt_u)  cause = CAUSE_TRAP;
      OP_TEQ:  if (eq)    cause = CAUSE_TRAP;
      OP_TNE:  if (!eq)   cause = CAUSE_TRAP;
      OP_PASSB: result = b;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/ex_hwreg_read.sv
module ex_hwreg_read #(
  parameter int DATA_W         = 32,
  parameter int SEL_W          = 5,
  parameter int MIN_LINE_BYTES = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] cycle_count,
  input  logic [DATA_W-1:0] user_local,
  output logic [DATA_W-1:0] value
);

  localparam logic [DATA_W-1:0] LINE_VAL = DATA_W'(MIN_LINE_BYTES);
  localparam logic [DATA_W-1:0] ONE_VAL  = DATA_W'(1);

  always_comb begin
    unique case (sel)
      SEL_W'(1):  value = LINE_VAL;
      SEL_W'(2):  value = cycle_count;
      SEL_W'(3):  value = ONE_VAL;
      SEL_W'(29): value = user_local;
      default:    value = '0;
    endcase
  end

endmodule

// File: rtl/ex_stage.sv
module ex_stage
  import ex_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int SEL_W          = 5,
  parameter int MIN_LINE_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                flush,
  input  logic                in_valid,
  input  logic [4:0]          in_op,
  input  logic [DATA_W-1:0]   in_rs_val,
  input  logic [DATA_W-1:0]   in_rt_val,
  input  logic [DATA_W-1:0]   in_imm,
  input  logic                in_use_imm,
  input  logic                in_wr_en,
  input  logic [SEL_W-1:0]    in_rd_sel,
  input  logic [4:0]          in_shamt,
  input  logic [DATA_W-1:0]   in_pc,
  input  logic [3:0]          in_cause,
  input  logic                in_in_slot,
  input  logic [DATA_W-1:0]   cycle_count,
  input  logic [DATA_W-1:0]   user_local,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_result,
  output logic                out_wr_en,
  output logic [DATA_W-1:0]   out_pc,
  output logic [3:0]          out_cause,
  output logic                out_in_slot
);

  ex_op_e              op;
  logic [DATA_W-1:0]   opnd_b;
  logic [DATA_W-1:0]   alu_res;
  logic [CAUSE_W-1:0]  alu_cause;
  logic                alu_discard;
  logic [DATA_W-1:0]   hw_val;

  assign op = ex_op_e'(in_op);

  ex_operand_sel #(.DATA_W(DATA_W)) u_opsel (
    .use_imm (in_use_imm),
    .rt_val  (in_rt_val),
    .imm_val (in_imm),
    .opnd_b  (opnd_b)
  );

  ex_alu #(.DATA_W(DATA_W), .SH_W(5)) u_alu (
    .op      (op),
    .a       (in_rs_val),
    .b       (opnd_b),
    .rt_val  (in_rt_val),
    .shamt   (in_shamt),
    .result  (alu_res),
    .cause   (alu_cause),
    .discard (alu_discard)
  );

  ex_hwreg_read #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .MIN_LINE_BYTES(MIN_LINE_BYTES)
  ) u_hwrd (
    .sel         (in_rd_sel),
    .cycle_count (cycle_count),
    .user_local  (user_local),
    .value       (hw_val)
  );

  // Next-state of the output register
  logic                reg_en;
  logic                nx_valid, nx_wr_en, nx_slot;
  logic [DATA_W-1:0]   nx_result, nx_pc;
  logic [CAUSE_W-1:0]  nx_cause;

  assign reg_en = flush | ~stall;

  always_comb begin
    if (flush) begin
      nx_valid  = 1'b0;
      nx_result = '0;
      nx_wr_en  = 1'b0;
      nx_pc     = '0;
      nx_cause  = CAUSE_NONE;
      nx_slot   = 1'b0;
    end else begin
      nx_valid = in_valid;
      nx_pc    = in_pc;
      nx_slot  = in_in_slot;
      if (in_cause != CAUSE_NONE) begin
        nx_result = '0;
        nx_cause  = in_cause;
        nx_wr_en  = in_wr_en;
      end else begin
        nx_result = (op == OP_HWRD) ? hw_val : alu_res;
        nx_cause  = alu_cause;
        nx_wr_en  = in_wr_en & ~alu_discard;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wr_en   <= 1'b0;
      out_pc      <= '0;
      out_cause   <= CAUSE_NONE;
      out_in_slot <= 1'b0;
    end else if (reg_en) begin
      out_valid   <= nx_valid;
      out_result  <= nx_result;
      out_wr_en   <= nx_wr_en;
      out_pc      <= nx_pc;
      out_cause   <= nx_cause;
      out_in_slot <= nx_slot;
    end
  end

  // Properties guarding the register behaviour
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ($stable(out_result) && $stable(out_cause) &&
                           $stable(out_valid) && $stable(out_wr_en))); // R9

  AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !out_wr_en && out_cause == CAUSE_NONE &&
               out_result == '0)); // R10

  AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !flush && in_cause != CAUSE_NONE) |=>
      (out_cause == $past(in_cause) && out_result == '0)); // R5

  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !flush) |=> (out_pc == $past(in_pc) &&
                            out_in_slot == $past(in_in_slot))); // R8

  AST_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !flush && is_trap_op(op)) |=> (out_result == '0)); // R4

  AST_MOVZ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !flush && in_cause == CAUSE_NONE && op == OP_MOVZ &&
     opnd_b != '0) |=> !out_wr_en); // R6

endmodule

// File: tb/test_ex_stage.sv
module test_ex_stage;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall, flush, in_valid, in_use_imm, in_wr_en, in_in_slot;
  logic [4:0]  in_op, in_rd_sel, in_shamt;
  logic [31:0] in_rs_val, in_rt_val, in_imm, in_pc, cycle_count, user_local;
  logic [3:0]  in_cause;
  logic        out_valid, out_wr_en, out_in_slot;
  logic [31:0] out_result, out_pc;
  logic [3:0]  out_cause;

  localparam int LINE = 16;

  always #4 clk = ~clk;

  ex_stage #(.DATA_W(32), .SEL_W(5), .MIN_LINE_BYTES(LINE)) i_ex_stage (
    .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
    .in_valid(in_valid), .in_op(in_op), .in_rs_val(in_rs_val),
    .in_rt_val(in_rt_val), .in_imm(in_imm), .in_use_imm(in_use_imm),
    .in_wr_en(in_wr_en), .in_rd_sel(in_rd_sel), .in_shamt(in_shamt),
    .in_pc(in_pc), .in_cause(in_cause), .in_in_slot(in_in_slot),
    .cycle_count(cycle_count), .user_local(user_local),
    .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
    .out_pc(out_pc), .out_cause(out_cause), .out_in_slot(out_in_slot)
  );

  typedef struct {
    logic        valid;
    logic [31:0] result;
    logic        wr;
    logic [31:0] pc;
    logic [3:0]  cause;
    logic        slot;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   n_checks = 0;
  int   n_fail   = 0;
  logic [31:0] pc_ctr = 32'h0000_1000;
  bit   done = 0;

  task automatic compare(input exp_t e);
    n_checks++;
    if (out_valid !== e.valid || out_result !== e.result || out_wr_en !== e.wr ||
        out_pc !== e.pc || out_cause !== e.cause || out_in_slot !== e.slot) begin
      n_fail++;
      $display("FAIL %s: got v=%0b res=%h wr=%0b pc=%h cause=%0d slot=%0b, exp v=%0b res=%h wr=%0b pc=%h cause=%0d slot=%0b",
               e.tag, out_valid, out_result, out_wr_en, out_pc, out_cause, out_in_slot,
               e.valid, e.result, e.wr, e.pc, e.cause, e.slot);
    end
  endtask

  // Independent expectation from the requirement text
  function automatic exp_t model(input logic [4:0] op, input logic [31:0] rs, rt,
      imm, input logic use_i, wr, input logic [4:0] rd, sh, input logic [3:0] cz,
      input logic slot, input logic [31:0] pc, cyc, ul);
    exp_t e;
    logic [31:0] b;
    logic [32:0] wide;
    b = use_i ? imm : rt;
    e.valid = 1'b1; e.pc = pc; e.slot = slot; e.wr = wr;
    e.result = 32'h0; e.cause = 4'd0;
    if (cz != 4'd0) begin
      e.cause = cz;
      return e;
    end
    case (op)
      5'd0, 5'd1: begin
        e.result = rs + b;
        wide = {rs[31], rs} + {b[31], b};
        if (op == 5'd1 && wide[32] != wide[31]) e.cause = 4'd12;
      end
      5'd2, 5'd3: begin
        e.result = rs - b;
        wide = {rs[31], rs} - {b[31], b};
        if (op == 5'd3 && wide[32] != wide[31]) e.cause = 4'd12;
      end
      5'd4: e.result = rs & b;
      5'd5: e.result = rs | b;
      5'd6: e.result = rs ^ b;
      5'd7: e.result = ~(rs | b);
      5'd8: e.result = ($signed(rs) < $signed(b)) ? 32'd1 : 32'd0;
      5'd9: e.result = (rs < b) ? 32'd1 : 32'd0;
      5'd10: e.result = rt << sh;
      5'd11: e.result = rt >> sh;
      5'd12: e.result = $signed(rt) >>> sh;
      5'd13: e.result = {b[15:0], 16'h0};
      5'd14: begin e.result = rs; if (b != 0) e.wr = 1'b0; end
      5'd15: begin e.result = rs; if (b == 0) e.wr = 1'b0; end
      5'd16: if ($signed(rs) >= $signed(b)) e.cause = 4'd13;
      5'd17: if (rs >= b) e.cause = 4'd13;
      5'd18: if ($signed(rs) < $signed(b)) e.cause = 4'd13;
      5'd19: if (rs < b) e.cause = 4'd13;
      5'd20: if (rs == b) e.cause = 4'd13;
      5'd21: if (rs != b) e.cause = 4'd13;
      5'd22: case (rd)
               5'd1: e.result = LINE;
               5'd2: e.result = cyc;
               5'd3: e.result = 32'd1;
               5'd29: e.result = ul;
               default: e.result = 32'd0;
             endcase
      5'd23: e.result = b;
      default: e.result = 32'd0;
    endcase
    return e;
  endfunction

  // Driver: applies one bundle at the falling edge and queues the expectation
  task automatic issue(input string tag, input logic [4:0] op, input logic [31:0] rs,
      rt, imm, input logic use_i, input logic [4:0] rd, sh, input logic [3:0] cz,
      input logic st = 1'b0, input logic fl = 1'b0);
    exp_t e;
    @(negedge clk);
    pc_ctr      = pc_ctr + 32'd4;
    cycle_count = cycle_count + 32'd7;
    in_valid = 1'b1; in_op = op; in_rs_val = rs; in_rt_val = rt; in_imm = imm;
    in_use_imm = use_i; in_wr_en = 1'b1; in_rd_sel = rd; in_shamt = sh;
    in_cause = cz; in_pc = pc_ctr; in_in_slot = pc_ctr[2]; stall = st; flush = fl;
    if (fl) begin
      e = '{1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b0, ""};
    end else if (st) begin
      e = last_exp;
    end else begin
      e = model(op, rs, rt, imm, use_i, 1'b1, rd, sh, cz, pc_ctr[2], pc_ctr,
                cycle_count, user_local);
    end
    e.tag = tag;
    last_exp = e;
    exp_q.push_back(e);
  endtask

  // Monitor: each queued item is due right after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; stall = 1'b0; flush = 1'b0; in_valid = 1'b0; in_op = 5'd0;
    in_rs_val = 0; in_rt_val = 0; in_imm = 0; in_use_imm = 0; in_wr_en = 0;
    in_rd_sel = 0; in_shamt = 0; in_pc = 0; in_cause = 0; in_in_slot = 0;
    cycle_count = 32'h100; user_local = 32'hCAFE_0042;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    r = '{1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b0, "R1 reset"};
    compare(r);
    last_exp = r;

    issue("R11 addu", 5'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    issue("R3 add no ovf", 5'd1, 32'h0000_0010, 32'hFFFF_FFF0, 0, 0, 0, 0, 0);
    issue("R3 add ovf", 5'd1, 32'h8FFF_FFFF, 32'h9000_0000, 0, 0, 0, 0, 0);
    issue("R3 add ovf pos", 5'd1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    issue("R3 sub ovf", 5'd3, 32'h8000_0003, 32'h4, 0, 0, 0, 0, 0);
    issue("R3 subu wraps", 5'd2, 32'h8000_0003, 32'h4, 0, 0, 0, 0, 0);
    issue("R2 imm select", 5'd0, 32'h10, 32'h1111, 32'h0000_0020, 1, 0, 0, 0);
    issue("R2 rt select", 5'd0, 32'h10, 32'h1111, 32'h0000_0020, 0, 0, 0, 0);
    issue("R4 teq hit", 5'd20, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, 0, 0);
    issue("R4 teq miss", 5'd20, 32'h1234_5679, 32'h1234_5678, 0, 0, 0, 0, 0);
    issue("R4 tne hit", 5'd21, 32'h1234_5678, 32'h1234_5679, 0, 0, 0, 0, 0);
    issue("R4 tne miss", 5'd21, 32'h5, 32'h5, 0, 0, 0, 0, 0);
    issue("R4 tge signed miss", 5'd16, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    issue("R4 tgeu hit", 5'd17, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    issue("R4 tlt signed hit", 5'd18, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 0);
    issue("R4 tltu miss", 5'd19, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 0);
    issue("R4 tge imm equal", 5'd16, 32'h0000_0042, 32'h0, 32'h0000_0042, 1, 0, 0, 0);
    issue("R5 cause kept on ovf add", 5'd1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 4'd8);
    issue("R5 cause kept on hwread", 5'd22, 0, 0, 0, 0, 5'd29, 0, 4'd5);
    issue("R6 movz keep", 5'd14, 32'hABCD, 32'h0, 0, 0, 0, 0, 0);
    issue("R6 movz drop", 5'd14, 32'hABCD, 32'h3, 0, 0, 0, 0, 0);
    issue("R6 movn keep", 5'd15, 32'hABCD, 32'h3, 0, 0, 0, 0, 0);
    issue("R6 movn drop", 5'd15, 32'hABCD, 32'h0, 0, 0, 0, 0, 0);
    issue("R7 sel0", 5'd22, 0, 0, 0, 0, 5'd0, 0, 0);
    issue("R7 sel1 line", 5'd22, 0, 0, 0, 0, 5'd1, 0, 0);
    issue("R7 sel2 cycle", 5'd22, 0, 0, 0, 0, 5'd2, 0, 0);
    issue("R7 sel3 one", 5'd22, 0, 0, 0, 0, 5'd3, 0, 0);
    issue("R7 sel29 user", 5'd22, 0, 0, 0, 0, 5'd29, 0, 0);
    issue("R7 sel7 other", 5'd22, 0, 0, 0, 0, 5'd7, 0, 0);
    issue("R11 and", 5'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 0, 0);
    issue("R11 or", 5'd5, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 0, 0);
    issue("R11 xor", 5'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 0, 0);
    issue("R11 nor", 5'd7, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 0, 0);
    issue("R11 slt", 5'd8, 32'hFFFF_FFFE, 32'h1, 0, 0, 0, 0, 0);
    issue("R11 sltu", 5'd9, 32'hFFFF_FFFE, 32'h1, 0, 0, 0, 0, 0);
    issue("R11 sll", 5'd10, 0, 32'h8000_0001, 0, 0, 0, 5'd4, 0);
    issue("R11 srl", 5'd11, 0, 32'h8000_0010, 0, 0, 0, 5'd4, 0);
    issue("R11 sra", 5'd12, 0, 32'h8000_0010, 0, 0, 0, 5'd4, 0);
    issue("R11 lui", 5'd13, 0, 0, 32'h0000_BEEF, 1, 0, 0, 0);
    issue("R11 passb", 5'd23, 32'h1, 32'h5A5A_5A5A, 0, 0, 0, 0, 0);
    issue("R8 pass before stall", 5'd0, 32'h1, 32'h2, 0, 0, 0, 0, 0);
    issue("R9 stall hold", 5'd0, 32'h99, 32'h99, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    issue("R9 stall hold ovf", 5'd1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    issue("R10 flush in stall", 5'd0, 32'h99, 32'h99, 0, 0, 0, 0, 4'd3, 1'b1, 1'b1);
    issue("R10 flush", 5'd0, 32'h5, 32'h5, 0, 0, 0, 0, 0, 1'b0, 1'b1);
    issue("R8 resume", 5'd0, 32'h5, 32'h6, 0, 0, 0, 0, 0);

    @(negedge clk);
    stall = 1'b0; flush = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: got %0d pending, exp 0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule